// File: doc/BRIEF.md
# Hart Status and Interrupt Control Registers

This block holds the machine-level status word, the interrupt-enable and interrupt-pending words, and the two delegation words of a single RISC-V style hart with XLEN = 32. Software reaches them through a CSR access port: a write strobe, a 12-bit CSR address and 32 bits of write data. Every write is passed through per-field write masks. The supervisor views of status, enable and pending are windows onto the machine registers. They are not separate storage.

Reads are combinational from the address. Writes take effect at the next rising clock edge. Two configuration inputs state whether supervisor mode and user mode exist. A status write that gives the previous-privilege field a mode that is not available is dropped for that field alone. Three hardware pending lines are merged into the pending word on every read. When a status write changes one of the fields that govern address translation, the block raises a one-cycle flush request for the translation cache in the following cycle.

Top module: `hart_stat_irq_csr`

## Requirements
- R1: A low `rst_n` sampled at a rising clock edge clears every register. After reset, reads of all eight mapped addresses return zero while the hardware pending lines are low, and `tlb_flush` is low.
- R2: A write to the machine status word (address 0x300) updates only these fields: SIE bit 1, MIE bit 3, SPIE bit 5, MPIE bit 7, SPP bit 8, MPP bits 12:11, FS bits 14:13, MPRV bit 17, SUM bit 18 and MXR bit 19. Every other bit keeps its old value.
- R3: The MPP field keeps its old value when the value written to it is 2, or is 1 while `has_smode` is low, or is 0 while `has_umode` is low. The other fields of the same write still take effect. The value 3 is always accepted.
- R4: After any status write, an FS field that is not zero is stored as 3.
- R5: Bit 31 (SD) of the status word reads 1 exactly when FS (bits 14:13) is 3 or XS (bits 16:15) is 3.
- R6: `tlb_flush` is high for the one cycle after the edge of a status write (0x300 or 0x100) that changed the stored value of MXR, MPP, MPRV or SUM. It is low in every other cycle.
- R7: A write to the supervisor status view (0x100) can change only UIE 0, SIE 1, UPIE 4, SPIE 5, SPP 8, FS 14:13, XS 16:15, SUM 18 and MXR 19. The merged word then obeys R2 through R6, so UIE, UPIE and XS never change. A read of 0x100 returns the status word ANDed with 0x800DE133.
- R8: In the enable word (0x304) only bits 1, 3, 5, 7 and 9 are writable. In the interrupt delegation word (0x303) only bits 1, 5 and 9 are writable.
- R9: A read of the supervisor enable view (0x104) returns enable AND interrupt delegation. A write to it changes only the enable bits whose delegation bit is set.
- R10: Software writes to the pending word (0x344) change only bits 1 and 5. A read of 0x344 returns those stored bits ORed with `hw_msip` at bit 3, `hw_mtip` at bit 7 and `hw_seip` at bit 9.
- R11: A read of the supervisor pending view (0x144) returns the R10 pending value AND interrupt delegation. A write to it changes only stored pending bits 1 and 5, and only where delegation is set.
- R12: In the exception delegation word (0x302) only bits 0 through 9, 12, 13 and 15 are writable.
- R13: Any other address reads as zero. A write to it changes no register and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed CSR |
| addr | input | 12 | CSR address for both read and write |
| wdata | input | 32 | Write data |
| has_smode | input | 1 | Supervisor mode is implemented |
| has_umode | input | 1 | User mode is implemented |
| hw_msip | input | 1 | Hardware machine software interrupt pending |
| hw_mtip | input | 1 | Hardware machine timer interrupt pending |
| hw_seip | input | 1 | Hardware supervisor external interrupt pending |
| rdata | output | 32 | Read data for `addr`, combinational |
| tlb_flush | output | 1 | One-cycle translation-cache flush request |

## Verification
Two events can land in the same cycle. A status write can arrive while the flush pulse of the previous status write is still on the output, and a write to a supervisor view can arrive while the delegation word it depends on was changed one cycle earlier. The bench provokes both with back-to-back writes: status writes that alternately change and do not change the translation fields, and a delegation write followed at once by supervisor view writes. A free-running reference model is compared with `rdata` and `tlb_flush` on every clock, so a pulse that is merged, stretched or taken from the wrong write is reported in the cycle where it goes wrong.

// File: rtl/hsic_pkg.sv
// Shared constants and types for the hart status / interrupt register block.
// Assumes a 32-bit register width and the standard 12-bit CSR address space.
package hsic_pkg;

    localparam int XLEN   = 32;
    localparam int ADDR_W = 12;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [ADDR_W-1:0] csr_addr_t;

    // CSR addresses served by this block
    localparam csr_addr_t A_MSTATUS = 12'h300;
    localparam csr_addr_t A_MEDELEG = 12'h302;
    localparam csr_addr_t A_MIDELEG = 12'h303;
    localparam csr_addr_t A_MIE     = 12'h304;
    localparam csr_addr_t A_MIP     = 12'h344;
    localparam csr_addr_t A_SSTATUS = 12'h100;
    localparam csr_addr_t A_SIE     = 12'h104;
    localparam csr_addr_t A_SIP     = 12'h144;

    // Status word bit positions
    localparam int B_UIE  = 0;
    localparam int B_SIE  = 1;
    localparam int B_MIE  = 3;
    localparam int B_UPIE = 4;
    localparam int B_SPIE = 5;
    localparam int B_MPIE = 7;
    localparam int B_SPP  = 8;
    localparam int B_MPP  = 11;
    localparam int B_FS   = 13;
    localparam int B_XS   = 15;
    localparam int B_MPRV = 17;
    localparam int B_SUM  = 18;
    localparam int B_MXR  = 19;
    localparam int B_SD   = XLEN - 1;

    // Interrupt bit positions
    localparam int B_SSIP = 1;
    localparam int B_MSIP = 3;
    localparam int B_STIP = 5;
    localparam int B_MTIP = 7;
    localparam int B_SEIP = 9;

    // Privilege encodings for the MPP field
    localparam logic [1:0] PRIV_U    = 2'd0;
    localparam logic [1:0] PRIV_S    = 2'd1;
    localparam logic [1:0] PRIV_RSVD = 2'd2;

    localparam word_t ONE = word_t'(1);

    localparam word_t MPP_MASK = (ONE << B_MPP) | (ONE << (B_MPP + 1));
    localparam word_t FS_MASK  = (ONE << B_FS)  | (ONE << (B_FS + 1));
    localparam word_t XS_MASK  = (ONE << B_XS)  | (ONE << (B_XS + 1));

    // Fields software may change through the machine status address
    localparam word_t M_WMASK = (ONE << B_SIE) | (ONE << B_MIE) | (ONE << B_SPIE) |
                                (ONE << B_MPIE) | (ONE << B_SPP) | MPP_MASK | FS_MASK |
                                (ONE << B_MPRV) | (ONE << B_SUM) | (ONE << B_MXR);

    // Fields reachable through the supervisor status view
    localparam word_t S_WMASK = (ONE << B_UIE) | (ONE << B_SIE) | (ONE << B_UPIE) |
                                (ONE << B_SPIE) | (ONE << B_SPP) | FS_MASK | XS_MASK |
                                (ONE << B_SUM) | (ONE << B_MXR);
    localparam word_t S_RMASK = S_WMASK | (ONE << B_SD);

    // Fields whose change requests a translation-cache flush
    localparam word_t FLUSH_MASK = MPP_MASK | (ONE << B_MPRV) | (ONE << B_SUM) | (ONE << B_MXR);

    localparam word_t IE_WMASK  = (ONE << B_SSIP) | (ONE << B_MSIP) | (ONE << B_STIP) |
                                  (ONE << B_MTIP) | (ONE << B_SEIP);
    localparam word_t ID_WMASK  = (ONE << B_SSIP) | (ONE << B_STIP) | (ONE << B_SEIP);
    localparam word_t IP_SWMASK = (ONE << B_SSIP) | (ONE << B_STIP);

    // Exception causes 0..9, 12, 13 and 15 may be delegated
    localparam word_t ED_WMASK  = ((ONE << 10) - ONE) | (ONE << 12) | (ONE << 13) | (ONE << 15);

    // One-hot register selection produced by the address decoder
    typedef struct packed {
        logic mstatus;
        logic sstatus;
        logic mie;
        logic sie;
        logic mip;
        logic sip;
        logic mideleg;
        logic medeleg;
    } sel_t;

endpackage

// File: rtl/hsic_decode.sv
// Address decoder: turns the CSR address into a one-hot read select and a
// write select that is active only with the write strobe.
// Assumes an unmapped address selects nothing.
module hsic_decode
    import hsic_pkg::*;
(
    input  csr_addr_t addr,
    input  logic      wr_en,
    output sel_t      rsel,
    output sel_t      wsel
);

    // Match the address against each served register, then gate with the strobe
    always_comb begin
        rsel = '0;
        case (addr)
            A_MSTATUS: rsel.mstatus = 1'b1;
            A_SSTATUS: rsel.sstatus = 1'b1;
            A_MIE:     rsel.mie     = 1'b1;
            A_SIE:     rsel.sie     = 1'b1;
            A_MIP:     rsel.mip     = 1'b1;
            A_SIP:     rsel.sip     = 1'b1;
            A_MIDELEG: rsel.mideleg = 1'b1;
            A_MEDELEG: rsel.medeleg = 1'b1;
            default:   rsel = '0;
        endcase
        wsel = wr_en ? rsel : '0;
    end

endmodule

// File: rtl/hsic_mreg.sv
// Generic masked register: on a write, only the bits set in both the fixed
// mask WMASK and the per-write lane mask take the new data.
// Assumes synchronous active-low reset to zero.
module hsic_mreg #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] WMASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] lane,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] en_bits;

    // Bits this write may touch
    assign en_bits = WMASK & lane;

    // Hold the register, merging new data into enabled bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= (q & ~en_bits) | (d & en_bits);
        end
    end

endmodule

// File: rtl/hsic_status.sv
// Machine status word. Supervisor view writes are first merged into the
// current word, then both paths share the same update rules: field masks,
// dropping of unsupported previous-privilege values, FS forced dirty, SD
// derived, and a flush request when a translation field changes.
// Assumes at most one status write per cycle (guaranteed by the decoder).
module hsic_status
    import hsic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_m,
    input  logic  wr_s,
    input  logic  has_s,
    input  logic  has_u,
    input  word_t wdata,
    output word_t st_o,
    output logic  flush_o
);

    word_t      st_q;
    word_t      src;
    word_t      mask;
    word_t      nxt;
    logic [1:0] mpp_req;
    logic       mpp_bad;
    logic       any_wr;

    assign any_wr = wr_m | wr_s;

    // Build the candidate status word for this cycle's write
    always_comb begin
        src     = wr_s ? ((st_q & ~S_WMASK) | (wdata & S_WMASK)) : wdata;
        mpp_req = src[B_MPP +: 2];
        mpp_bad = (mpp_req == PRIV_RSVD) ||
                  ((mpp_req == PRIV_S) && !has_s) ||
                  ((mpp_req == PRIV_U) && !has_u);
        mask    = mpp_bad ? (M_WMASK & ~MPP_MASK) : M_WMASK;
        nxt     = (st_q & ~mask) | (src & mask);
        if (nxt[B_FS +: 2] != 2'b00) begin
            nxt[B_FS +: 2] = 2'b11;
        end
        nxt[B_SD] = (nxt[B_FS +: 2] == 2'b11) || (nxt[B_XS +: 2] == 2'b11);
    end

    // Store the status word and register the flush request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            flush_o <= 1'b0;
        end else begin
            flush_o <= any_wr && (((nxt ^ st_q) & FLUSH_MASK) != '0);
            if (any_wr) begin
                st_q <= nxt;
            end
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/hsic_rdmux.sv
// Read multiplexer: selects the addressed register or view. Pending reads
// include the hardware pending lines; supervisor views are masked.
// Assumes a one-hot (or empty) select, so an AND-OR tree suffices.
module hsic_rdmux
    import hsic_pkg::*;
(
    input  sel_t  rsel,
    input  word_t st,
    input  word_t ie,
    input  word_t ip_sw,
    input  word_t id,
    input  word_t ed,
    input  logic  hw_msip,
    input  logic  hw_mtip,
    input  logic  hw_seip,
    output word_t rdata
);

    word_t ip_full;

    // Merge hardware pending lines into the stored software bits
    always_comb begin
        ip_full         = ip_sw;
        ip_full[B_MSIP] = ip_sw[B_MSIP] | hw_msip;
        ip_full[B_MTIP] = ip_sw[B_MTIP] | hw_mtip;
        ip_full[B_SEIP] = ip_sw[B_SEIP] | hw_seip;
    end

    // AND-OR selection of the read value
    always_comb begin
        rdata = ({XLEN{rsel.mstatus}} & st)
              | ({XLEN{rsel.sstatus}} & (st & S_RMASK))
              | ({XLEN{rsel.mie}}     & ie)
              | ({XLEN{rsel.sie}}     & (ie & id))
              | ({XLEN{rsel.mip}}     & ip_full)
              | ({XLEN{rsel.sip}}     & (ip_full & id))
              | ({XLEN{rsel.mideleg}} & id)
              | ({XLEN{rsel.medeleg}} & ed);
    end

endmodule

// File: rtl/hart_stat_irq_csr.sv
// Top of the hart status / interrupt register block. Decodes the CSR
// address, routes writes (supervisor views write through delegation lanes)
// and returns read data combinationally.
// Assumes one CSR access per cycle and synchronous active-low reset.
module hart_stat_irq_csr
    import hsic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [XLEN-1:0]     wdata,
    input  logic                has_smode,
    input  logic                has_umode,
    input  logic                hw_msip,
    input  logic                hw_mtip,
    input  logic                hw_seip,
    output logic [XLEN-1:0]     rdata,
    output logic                tlb_flush
);

    sel_t  rsel;
    sel_t  wsel;
    word_t st_w;
    word_t ie_w;
    word_t ip_w;
    word_t id_w;
    word_t ed_w;
    word_t ie_lane;
    word_t ip_lane;

    hsic_decode u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rsel  (rsel),
        .wsel  (wsel)
    );

    hsic_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_m    (wsel.mstatus),
        .wr_s    (wsel.sstatus),
        .has_s   (has_smode),
        .has_u   (has_umode),
        .wdata   (wdata),
        .st_o    (st_w),
        .flush_o (tlb_flush)
    );

    // Supervisor views may only reach bits that are delegated
    assign ie_lane = wsel.sie ? id_w : '1;
    assign ip_lane = wsel.sip ? id_w : '1;

    hsic_mreg #(.WIDTH(XLEN), .WMASK(IE_WMASK)) u_ie (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.mie | wsel.sie),
        .lane  (ie_lane),
        .d     (wdata),
        .q     (ie_w)
    );

    hsic_mreg #(.WIDTH(XLEN), .WMASK(IP_SWMASK)) u_ip (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.mip | wsel.sip),
        .lane  (ip_lane),
        .d     (wdata),
        .q     (ip_w)
    );

    hsic_mreg #(.WIDTH(XLEN), .WMASK(ID_WMASK)) u_id (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.mideleg),
        .lane  ('1),
        .d     (wdata),
        .q     (id_w)
    );

    hsic_mreg #(.WIDTH(XLEN), .WMASK(ED_WMASK)) u_ed (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wsel.medeleg),
        .lane  ('1),
        .d     (wdata),
        .q     (ed_w)
    );

    hsic_rdmux u_rd (
        .rsel    (rsel),
        .st      (st_w),
        .ie      (ie_w),
        .ip_sw   (ip_w),
        .id      (id_w),
        .ed      (ed_w),
        .hw_msip (hw_msip),
        .hw_mtip (hw_mtip),
        .hw_seip (hw_seip),
        .rdata   (rdata)
    );

endmodule

// File: rtl/hsic_chk.sv
// Property checker for hart_stat_irq_csr, attached by bind. Relates the
// port-level read data and flush output to the stored status and
// delegation words over time.
// Assumes synchronous active-low reset; checks past values only once one
// full cycle out of reset has elapsed.
module hsic_chk
    import hsic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  csr_addr_t addr,
    input  word_t     rdata,
    input  logic      flush,
    input  word_t     st_q,
    input  word_t     id_q
);

    logic armed;

    // Marks that the previous edge was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2: bits outside the writable set never move
    assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> $stable(st_q & ~(M_WMASK | (ONE << B_SD))));

    // R3: the reserved privilege value is never stored
    assert_mpp_not_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[B_MPP +: 2] != PRIV_RSVD);

    // R4: a status read never shows the two partial FS encodings
    assert_fs_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_MSTATUS) |-> (rdata[B_FS +: 2] == 2'b00 || rdata[B_FS +: 2] == 2'b11));

    // R5: SD on the read port follows FS and XS of the same read
    assert_sd_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_MSTATUS) |->
            (rdata[B_SD] == ((rdata[B_FS +: 2] == 2'b11) || (rdata[B_XS +: 2] == 2'b11))));

    // R6: a flush pulse follows only a status write in the previous cycle
    assert_flush_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && flush) |->
            ($past(wr_en) && ($past(addr) == A_MSTATUS || $past(addr) == A_SSTATUS)));

    // R7: the supervisor status view exposes no machine-only field
    assert_sview_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_SSTATUS) |-> (((rdata & ~S_RMASK) == '0) && (rdata[B_SD] == st_q[B_SD])));

    // R9: the supervisor enable view never shows an undelegated bit
    assert_sie_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_SIE) |-> ((rdata & ~id_q) == '0));

endmodule

bind hart_stat_irq_csr hsic_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .rdata (rdata),
    .flush (tlb_flush),
    .st_q  (st_w),
    .id_q  (id_w)
);

// File: tb/hart_stat_irq_csr_tb_top.sv
`timescale 1ns/1ps
// Bench for hart_stat_irq_csr: a behavioural reference model advances with
// every clock and is compared with rdata and tlb_flush in every cycle.
module hart_stat_irq_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        has_smode = 1'b0;
    logic        has_umode = 1'b0;
    logic        hw_msip = 1'b0;
    logic        hw_mtip = 1'b0;
    logic        hw_seip = 1'b0;
    logic [31:0] rdata;
    logic        tlb_flush;

    // Configuration requested by the stimulus, applied at the next step
    bit cfg_s = 1'b1, cfg_u = 1'b1;
    bit cfg_msip = 1'b0, cfg_mtip = 1'b0, cfg_seip = 1'b0;

    int vectors = 0;
    int misses  = 0;

    // Reference model state
    logic [31:0] m_stat = '0, m_en = '0, m_pend = '0, m_ideleg = '0, m_edeleg = '0;
    bit          m_flush = 1'b0;

    always #4 clk = ~clk;

    hart_stat_irq_csr dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .has_smode (has_smode),
        .has_umode (has_umode),
        .hw_msip   (hw_msip),
        .hw_mtip   (hw_mtip),
        .hw_seip   (hw_seip),
        .rdata     (rdata),
        .tlb_flush (tlb_flush)
    );

    function automatic logic [31:0] pend_now();
        logic [31:0] p = m_pend;
        if (hw_msip) p[3] = 1'b1;
        if (hw_mtip) p[7] = 1'b1;
        if (hw_seip) p[9] = 1'b1;
        return p;
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        case (a)
            12'h300: return m_stat;
            12'h100: return m_stat & 32'h800D_E133;
            12'h304: return m_en;
            12'h104: return m_en & m_ideleg;
            12'h344: return pend_now();
            12'h144: return pend_now() & m_ideleg;
            12'h303: return m_ideleg;
            12'h302: return m_edeleg;
            default: return 32'h0;
        endcase
    endfunction

    // Status update rules as listed in the requirements
    function automatic void status_apply(logic [31:0] cand);
        logic [31:0] nv;
        logic [1:0]  pp;
        bit          hold_pp;
        nv = m_stat;
        pp = cand[12:11];
        hold_pp = (pp == 2'd2) || (pp == 2'd1 && !has_smode) || (pp == 2'd0 && !has_umode);
        foreach (cand[b]) begin
            if (b inside {1, 3, 5, 7, 8, 13, 14, 17, 18, 19}) nv[b] = cand[b];
            if (b inside {11, 12} && !hold_pp) nv[b] = cand[b];
        end
        if (nv[14:13] != 2'b00) nv[14:13] = 2'b11;
        nv[31] = (nv[14:13] == 2'b11) || (nv[16:15] == 2'b11);
        m_flush = (nv[12:11] != m_stat[12:11]) || (nv[19:17] != m_stat[19:17]);
        m_stat = nv;
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        m_flush = 1'b0;
        case (a)
            12'h300: status_apply(d);
            12'h100: status_apply((m_stat & ~32'h000D_E133) | (d & 32'h000D_E133));
            12'h304: m_en = d & 32'h0000_02AA;
            12'h104: m_en = (m_en & ~m_ideleg) | (d & m_ideleg & 32'h0000_02AA);
            12'h344: m_pend = d & 32'h0000_0022;
            12'h144: m_pend = (m_pend & ~(m_ideleg & 32'h22)) | (d & m_ideleg & 32'h22);
            12'h303: m_ideleg = d & 32'h0000_0222;
            12'h302: m_edeleg = d & 32'h0000_B3FF;
            default: ;
        endcase
    endfunction

    function automatic string tag_for(logic [11:0] a);
        case (a)
            12'h300: return "R2";
            12'h100: return "R7";
            12'h304: return "R8";
            12'h303: return "R8";
            12'h104: return "R9";
            12'h344: return "R10";
            12'h144: return "R11";
            12'h302: return "R12";
            default: return "R13";
        endcase
    endfunction

    // One clock of stimulus: drive at the falling edge, compare, advance model
    task automatic step(bit w, logic [11:0] a, logic [31:0] d, string tag);
        logic [31:0] exp_rd;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d;
        has_smode = cfg_s; has_umode = cfg_u;
        hw_msip = cfg_msip; hw_mtip = cfg_mtip; hw_seip = cfg_seip;
        #1;
        exp_rd = model_read(a);
        vectors++;
        if (rdata !== exp_rd || tlb_flush !== m_flush) begin
            misses++;
            $display("FAIL %s addr=%h rdata=%h expected=%h flush=%b expected=%b",
                     tag, a, rdata, exp_rd, tlb_flush, m_flush);
        end
        if (w) model_write(a, d);
        else   m_flush = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, string tag);
        step(1'b0, a, 32'h0, tag);
    endtask

    // Watchdog: a hung run is a failed check and still summarises
    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: cycles actual=200000 expected=<200000");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1: hold reset, then read every mapped register
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        rd(12'h300, "R1"); rd(12'h100, "R1"); rd(12'h304, "R1"); rd(12'h104, "R1");
        rd(12'h344, "R1"); rd(12'h144, "R1"); rd(12'h303, "R1"); rd(12'h302, "R1");

        // R2 R4 R5 R6: all-ones status write, then read back with flush
        step(1'b1, 12'h300, 32'hFFFF_FFFF, "R2");
        rd(12'h300, "R6");
        rd(12'h100, "R7");

        // R3: reserved MPP dropped, other fields land
        step(1'b1, 12'h300, 32'h0000_1000 | 32'h0000_0008, "R3");
        rd(12'h300, "R3");
        cfg_s = 1'b0;
        step(1'b1, 12'h300, 32'h0000_0800, "R3");
        rd(12'h300, "R3");
        cfg_s = 1'b1; cfg_u = 1'b0;
        step(1'b1, 12'h300, 32'h0000_0000, "R3");
        rd(12'h300, "R3");
        cfg_u = 1'b1;

        // R4 R5: FS partial value becomes dirty; FS zero clears SD
        step(1'b1, 12'h300, 32'h0000_2000, "R4");
        rd(12'h300, "R5");
        step(1'b1, 12'h300, 32'h0000_0000, "R5");
        rd(12'h300, "R5");

        // R7: supervisor status view write
        step(1'b1, 12'h100, 32'hFFFF_FFFF, "R7");
        rd(12'h100, "R7");
        rd(12'h300, "R7");

        // R6: back-to-back writes, changing then unchanged then changing
        step(1'b1, 12'h300, 32'h0004_0000, "R6");
        step(1'b1, 12'h300, 32'h0004_0000, "R6");
        step(1'b1, 12'h300, 32'h0002_0000, "R6");
        rd(12'h300, "R6");
        rd(12'h300, "R6");

        // R8 R9: enable and delegation masks, supervisor enable view
        step(1'b1, 12'h304, 32'hFFFF_FFFF, "R8");
        step(1'b1, 12'h303, 32'hFFFF_FFFF, "R8");
        rd(12'h303, "R8");
        rd(12'h104, "R9");
        step(1'b1, 12'h303, 32'h0000_0020, "R9");
        step(1'b1, 12'h104, 32'h0000_0000, "R9");
        rd(12'h304, "R9");

        // R10 R11: software and hardware pending bits, supervisor pending view
        step(1'b1, 12'h344, 32'hFFFF_FFFF, "R10");
        rd(12'h344, "R10");
        cfg_msip = 1'b1; cfg_mtip = 1'b1; cfg_seip = 1'b1;
        rd(12'h344, "R10");
        rd(12'h144, "R11");
        step(1'b1, 12'h144, 32'h0000_0000, "R11");
        rd(12'h344, "R11");
        cfg_msip = 1'b0; cfg_mtip = 1'b0; cfg_seip = 1'b0;

        // R12: exception delegation mask
        step(1'b1, 12'h302, 32'hFFFF_FFFF, "R12");
        rd(12'h302, "R12");

        // R13: unmapped address write changes nothing
        step(1'b1, 12'h305, 32'hFFFF_FFFF, "R13");
        rd(12'h305, "R13");
        rd(12'h300, "R13");
        rd(12'h304, "R13");

        // Mixed traffic across all addresses and configurations
        for (int i = 0; i < 600; i++) begin
            logic [11:0] pick;
            logic [31:0] dv;
            case ($urandom_range(0, 9))
                0: pick = 12'h300; 1: pick = 12'h100; 2: pick = 12'h304;
                3: pick = 12'h104; 4: pick = 12'h344; 5: pick = 12'h144;
                6: pick = 12'h303; 7: pick = 12'h302; 8: pick = 12'h300;
                default: pick = 12'h7C0;
            endcase
            dv = $urandom();
            cfg_s = 1'($urandom_range(0, 1));
            cfg_u = 1'($urandom_range(0, 1));
            cfg_msip = 1'($urandom_range(0, 1));
            cfg_mtip = 1'($urandom_range(0, 1));
            cfg_seip = 1'($urandom_range(0, 1));
            step(1'($urandom_range(0, 1)), pick, dv, tag_for(pick));
        end
        rd(12'h300, "R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule